// File: doc/BRIEF.md
# Destination Address Acceptance Filter

This block decides, for every received frame, whether the frame's 48-bit destination address should be taken in. It keeps a bank of sixteen exact-match address slots, each gated by its own valid flag, and a 4096-bit multicast hash bitmap organised as 128 words of 32 bits. A group address that finds no exact slot is reduced to a 12-bit hash taken from one of four selectable windows in its upper bits, and the bitmap bit at that hash decides acceptance. The all-ones broadcast address has its own enable and a single promiscuous enable accepts everything.

Software programs the block through a one-cycle write strobe carrying a word offset and 32 bits of data: address slots are written as a low and a high word, hash bits are set one at a time or wiped all at once, and a control word selects the hash window and the broadcast and promiscuous enables. The receive path presents an address with a valid strobe and gets a registered accept flag and a match kind exactly one cycle later. Slot 0 is meant for the station's own address and slots 1 to 15 for the first multicast addresses, with further groups spilling into the hash bitmap; the block itself treats all sixteen slots alike.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset every slot is invalid, the bitmap is all zero, the hash window is 0 and broadcast and promiscuous acceptance are off, so every lookup returns reject with kind NONE (0).
- R2: A lookup strobed on `lk_valid` in cycle N produces `res_valid` high in cycle N+1 only; while `res_valid` is low, `res_accept` is 0 and `res_kind` is 0.
- R3: Slot k is written at offset 2k (low word) and 2k+1 (high word). The low word holds address bytes 0 to 3 with byte 0 in bits 7:0; the high word holds byte 4 in bits 7:0, byte 5 in bits 15:8 and the valid flag in bit 31. `lk_addr[7:0]` is byte 0 and `lk_addr[47:40]` is byte 5.
- R4: A slot matches only while its valid flag is 1; writing the high word with bit 31 at 0 removes the match at once while the low word keeps its value, and writing it back with bit 31 at 1 restores the match.
- R5: An address equal to any valid slot, slot 0 through slot 15, is accepted with kind EXACT (1); an address that differs from the slot in any byte does not match it.
- R6: The hash is address bits 47:36 in window 0, 46:35 in window 1, 45:34 in window 2 and 43:32 in window 3; for bytes 01 AA 00 12 34 56 (byte 0 first) the hashes are 0x563, 0xAC6, 0x58D and 0x634. The window is control-word bits 1:0 at offset 32.
- R7: Writing offset 33 sets bitmap bit hash[4:0] of word hash[11:5], with the hash in data bits 11:0; the other bits of that word, and all other words, keep their values.
- R8: Writing offset 34 clears every bit of the bitmap.
- R9: A non-broadcast address with no exact match is accepted with kind HASH (2) only when its group bit (`lk_addr[0]`) is 1 and its bitmap bit is 1.
- R10: The all-ones address is accepted, with kind BCAST (3), only when control bit 2 is 1; with the bit at 0 it is rejected with kind NONE even if a slot or bitmap bit would match it. No other address reports BCAST.
- R11: When an address both matches a slot and hits the bitmap, the kind reported is EXACT.
- R12: With control bit 3 (promiscuous) at 1, every lookup is accepted and the kind still reports which match, if any, was found.
- R13: A lookup in the same cycle as a host write sees the table as it was before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all state on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Host write strobe, one write per cycle |
| host_addr | input | 6 | Host word offset: slots 0-31, control 32, hash set 33, hash clear 34 |
| host_wdata | input | 32 | Host write data |
| lk_valid | input | 1 | Lookup strobe |
| lk_addr | input | 48 | Destination address to look up, byte 0 in bits 7:0 |
| res_valid | output | 1 | Lookup result present |
| res_accept | output | 1 | Frame accepted |
| res_kind | output | 2 | Match kind: 0 none, 1 exact, 2 hash, 3 broadcast |

## Verification
On every cycle the assertions check the result timing against the strobe, the quiet outputs between results, that any reported match kind comes with acceptance, that unicast addresses never report a hash match and that only the all-ones address can report broadcast. What the table actually holds can only be shown by the bench's scenarios: byte packing of the slot words, the valid flag gating, the four hash windows with their exact values, bit-level indexing and OR behaviour of the bitmap, the wipe, priority between kinds, promiscuous acceptance and the old-contents rule for a write that coincides with a lookup.

// File: rtl/addr_filt_pkg.sv
// Shared types and constants of the destination address filter.
// Assumes: addresses are 48 bits with byte 0 in bits 7:0.
package addr_filt_pkg;

    localparam int MAC_W  = 48;
    localparam int HOST_W = 32;

    // Match kind reported with every lookup result
    typedef enum logic [1:0] {
        KIND_NONE  = 2'd0,
        KIND_EXACT = 2'd1,
        KIND_HASH  = 2'd2,
        KIND_BCAST = 2'd3
    } match_kind_e;

    // Hash window selections
    typedef enum logic [1:0] {
        WIN_47_36 = 2'd0,
        WIN_46_35 = 2'd1,
        WIN_45_34 = 2'd2,
        WIN_43_32 = 2'd3
    } hash_win_e;

endpackage

// File: rtl/hash_index_calc.sv
// Extracts the multicast hash index from the upper 16 address bits.
// Assumes: hi_addr is address bits 47:32; HASH_W fits every window.
module hash_index_calc
    import addr_filt_pkg::*;
#(
    parameter int HASH_W = 12
) (
    input  logic [1:0]        win_sel,
    input  logic [15:0]       hi_addr,
    output logic [HASH_W-1:0] hash_idx
);

    // Select the bit window named by the window control
    always_comb begin
        unique case (hash_win_e'(win_sel))
            WIN_47_36: hash_idx = hi_addr[15 -: HASH_W];
            WIN_46_35: hash_idx = hi_addr[14 -: HASH_W];
            WIN_45_34: hash_idx = hi_addr[13 -: HASH_W];
            default:   hash_idx = hi_addr[11 -: HASH_W];
        endcase
    end

endmodule

// File: rtl/addr_entry_bank.sv
// Bank of exact-match address slots, each with a valid flag, compared
// in parallel against one lookup address.
// Assumes: one host word write per cycle; the high word carries bytes
// 4 and 5 in bits 15:0 and the valid flag in bit 31.
module addr_entry_bank
    import addr_filt_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    parameter int IDX_W       = $clog2(NUM_ENTRIES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       wr_idx,
    input  logic                   wr_high,
    input  logic [HOST_W-1:0]      wr_data,
    input  logic [MAC_W-1:0]       cmp_addr,
    output logic [NUM_ENTRIES-1:0] hit_vec
);

    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_slot
        logic [MAC_W-1:0] addr_q;
        logic             valid_q;

        // Hold the slot's address and valid flag, updated per host word
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                addr_q  <= '0;
                valid_q <= 1'b0;
            end else if (wr_en && wr_idx == IDX_W'(e)) begin
                if (wr_high) begin
                    addr_q[MAC_W-1:32] <= wr_data[15:0];
                    valid_q            <= wr_data[31];
                end else begin
                    addr_q[31:0] <= wr_data;
                end
            end
        end

        // Slot hits only while valid and equal in all 48 bits
        assign hit_vec[e] = valid_q && (addr_q == cmp_addr);
    end

endmodule

// File: rtl/mcast_hash_table.sv
// Multicast hash bitmap: words of WORD_W bits, one bit set per write,
// wiped in one cycle, read one bit combinationally.
// Assumes: set and wipe in the same cycle resolve to the wipe.
module mcast_hash_table #(
    parameter int HASH_W = 12,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic [HASH_W-1:0] set_idx,
    input  logic              clr_all,
    input  logic [HASH_W-1:0] rd_idx,
    output logic              rd_bit
);

    localparam int BIT_W     = $clog2(WORD_W);
    localparam int ROW_W     = HASH_W - BIT_W;
    localparam int NUM_WORDS = 1 << ROW_W;

    logic [WORD_W-1:0] tbl_q [NUM_WORDS];

    logic [ROW_W-1:0] set_row;
    logic [BIT_W-1:0] set_bit;
    logic [ROW_W-1:0] rd_row;
    logic [BIT_W-1:0] rd_sel;

    assign set_row = set_idx[HASH_W-1:BIT_W];
    assign set_bit = set_idx[BIT_W-1:0];
    assign rd_row  = rd_idx[HASH_W-1:BIT_W];
    assign rd_sel  = rd_idx[BIT_W-1:0];

    // Wipe on reset or request, else OR one bit into its word
    always_ff @(posedge clk) begin
        if (!rst_n || clr_all) begin
            for (int w = 0; w < NUM_WORDS; w++) begin
                tbl_q[w] <= '0;
            end
        end else if (set_en) begin
            tbl_q[set_row][set_bit] <= 1'b1;
        end
    end

    // Read the addressed bit from the current contents
    assign rd_bit = tbl_q[rd_row][rd_sel];

endmodule

// File: rtl/rx_addr_filter.sv
// Destination address acceptance filter: host register decode, control
// word, exact-match bank, hash bitmap and a registered accept decision.
// Assumes: lookup and host write may share a cycle; the lookup then sees
// the contents from before the write.
module rx_addr_filter
    import addr_filt_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    parameter int HASH_W      = 12,
    parameter int WORD_W      = 32,
    parameter int HOST_AW     = $clog2(2 * NUM_ENTRIES + 3)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_we,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [31:0]        host_wdata,
    input  logic               lk_valid,
    input  logic [47:0]        lk_addr,
    output logic               res_valid,
    output logic               res_accept,
    output logic [1:0]         res_kind
);

    localparam int IDX_W     = $clog2(NUM_ENTRIES);
    localparam int SLOT_WRDS = 2 * NUM_ENTRIES;
    localparam int OFS_CTRL  = SLOT_WRDS;
    localparam int OFS_HSET  = SLOT_WRDS + 1;
    localparam int OFS_HCLR  = SLOT_WRDS + 2;

    // Host decode
    logic slot_wr, ctrl_wr, hset_wr, hclr_wr;
    assign slot_wr = host_we && (host_addr < HOST_AW'(SLOT_WRDS));
    assign ctrl_wr = host_we && (host_addr == HOST_AW'(OFS_CTRL));
    assign hset_wr = host_we && (host_addr == HOST_AW'(OFS_HSET));
    assign hclr_wr = host_we && (host_addr == HOST_AW'(OFS_HCLR));

    // Control word
    logic [1:0] ctl_win_q;
    logic       ctl_bcast_q;
    logic       ctl_promisc_q;

    // Latch hash window, broadcast and promiscuous enables
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_win_q     <= 2'd0;
            ctl_bcast_q   <= 1'b0;
            ctl_promisc_q <= 1'b0;
        end else if (ctrl_wr) begin
            ctl_win_q     <= host_wdata[1:0];
            ctl_bcast_q   <= host_wdata[2];
            ctl_promisc_q <= host_wdata[3];
        end
    end

    // Exact-match bank
    logic [NUM_ENTRIES-1:0] hit_vec;

    addr_entry_bank #(
        .NUM_ENTRIES (NUM_ENTRIES),
        .IDX_W       (IDX_W)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (slot_wr),
        .wr_idx   (host_addr[IDX_W:1]),
        .wr_high  (host_addr[0]),
        .wr_data  (host_wdata),
        .cmp_addr (lk_addr),
        .hit_vec  (hit_vec)
    );

    // Hash index and bitmap
    logic [HASH_W-1:0] lk_hash;
    logic              hash_bit;

    hash_index_calc #(
        .HASH_W (HASH_W)
    ) u_hidx (
        .win_sel  (ctl_win_q),
        .hi_addr  (lk_addr[47:32]),
        .hash_idx (lk_hash)
    );

    mcast_hash_table #(
        .HASH_W (HASH_W),
        .WORD_W (WORD_W)
    ) u_tab (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (hset_wr),
        .set_idx (host_wdata[HASH_W-1:0]),
        .clr_all (hclr_wr),
        .rd_idx  (lk_hash),
        .rd_bit  (hash_bit)
    );

    // Accept decision
    logic        is_bcast;
    match_kind_e kind_d;
    logic        accept_d;

    assign is_bcast = &lk_addr;

    // Broadcast overrides, then exact slots, then group-address hash
    always_comb begin
        if (is_bcast) begin
            kind_d = ctl_bcast_q ? KIND_BCAST : KIND_NONE;
        end else if (|hit_vec) begin
            kind_d = KIND_EXACT;
        end else if (lk_addr[0] && hash_bit) begin
            kind_d = KIND_HASH;
        end else begin
            kind_d = KIND_NONE;
        end
        accept_d = ctl_promisc_q || (kind_d != KIND_NONE);
    end

    // Register the result one cycle after the strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid  <= 1'b0;
            res_accept <= 1'b0;
            res_kind   <= KIND_NONE;
        end else begin
            res_valid  <= lk_valid;
            res_accept <= lk_valid && accept_d;
            res_kind   <= lk_valid ? kind_d : KIND_NONE;
        end
    end

endmodule

// File: rtl/filter_checker.sv
// Port-level properties of the destination address filter, bound to
// every instance of the top module.
// Assumes: synchronous active-low reset on rst_n.
module filter_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        lk_valid,
    input logic [47:0] lk_addr,
    input logic        res_valid,
    input logic        res_accept,
    input logic [1:0]  res_kind
);

    assert_result_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> res_valid);

    assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !res_valid);

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (!res_accept && res_kind == 2'd0));

    assert_kind_accepts_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_kind != 2'd0) |-> res_accept);

    assert_unicast_no_hash_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !lk_addr[0]) |=> (res_kind != 2'd2));

    assert_bcast_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && &lk_addr) |=> (res_kind == 2'd0 || res_kind == 2'd3));

    assert_bcast_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !(&lk_addr)) |=> (res_kind != 2'd3));

endmodule

bind rx_addr_filter filter_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_valid   (lk_valid),
    .lk_addr    (lk_addr),
    .res_valid  (res_valid),
    .res_accept (res_accept),
    .res_kind   (res_kind)
);

// File: tb/sim_rx_addr_filter.sv
// Scoreboard bench: lookups push expected results, a monitor pops and
// compares them one cycle later.
module sim_rx_addr_filter;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [5:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic        lk_valid = 1'b0;
    logic [47:0] lk_addr = '0;
    logic        res_valid;
    logic        res_accept;
    logic [1:0]  res_kind;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        bit       acc;
        bit [1:0] kind;
        string    tag;
    } exp_t;

    exp_t exp_q[$];

    localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;
    localparam logic [47:0] UNI   = 48'h6655_4433_2210;
    localparam logic [47:0] EXMC  = 48'h5634_1200_AA01;
    localparam logic [47:0] A0    = 48'h0A0B_0C0D_0E02;
    localparam logic [47:0] A15   = 48'h7788_99AA_BBCC;
    localparam logic [47:0] M7    = 48'h1122_3344_5567;
    localparam logic [47:0] A4    = 48'h0102_0304_0506;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rx_addr_filter u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .lk_valid   (lk_valid),
        .lk_addr    (lk_addr),
        .res_valid  (res_valid),
        .res_accept (res_accept),
        .res_kind   (res_kind)
    );

    task automatic check(input bit ok, input string tag, input string act, input string exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %s expected %s", tag, act, exp);
        end
    endtask

    // All driver tasks start and end at a falling edge
    task automatic host_write(input logic [5:0] a, input logic [31:0] d);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic lookup(input logic [47:0] a, input bit acc, input bit [1:0] kind, input string tag);
        exp_t e;
        e.acc = acc; e.kind = kind; e.tag = tag;
        exp_q.push_back(e);
        lk_valid = 1'b1; lk_addr = a;
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    task automatic write_and_lookup(input logic [5:0] wa, input logic [31:0] wd,
                                    input logic [47:0] a, input bit acc,
                                    input bit [1:0] kind, input string tag);
        exp_t e;
        e.acc = acc; e.kind = kind; e.tag = tag;
        exp_q.push_back(e);
        host_we = 1'b1; host_addr = wa; host_wdata = wd;
        lk_valid = 1'b1; lk_addr = a;
        @(negedge clk);
        host_we = 1'b0; lk_valid = 1'b0;
    endtask

    task automatic set_slot(input int k, input logic [47:0] a);
        host_write(6'(2 * k), a[31:0]);
        host_write(6'(2 * k + 1), {1'b1, 15'd0, a[47:32]});
    endtask

    task automatic set_ctrl(input logic [1:0] win, input bit bc, input bit pr);
        host_write(6'd32, {28'd0, pr, bc, win});
    endtask

    task automatic hash_set(input logic [11:0] idx);
        host_write(6'd33, {20'd0, idx});
    endtask

    task automatic hash_wipe();
        host_write(6'd34, 32'd0);
    endtask

    // Monitor: compare each result with the oldest expectation
    always @(negedge clk) begin
        if (rst_n) begin
            if (res_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2 unexpected result", "res_valid=1", "no result");
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(res_accept == e.acc && res_kind == e.kind, e.tag,
                          $sformatf("acc=%0d kind=%0d", res_accept, res_kind),
                          $sformatf("acc=%0d kind=%0d", e.acc, e.kind));
                end
            end else begin
                check(!res_accept && res_kind == 2'd0, "R2 idle outputs",
                      $sformatf("acc=%0d kind=%0d", res_accept, res_kind), "acc=0 kind=0");
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [11:0] win_idx [4];
        win_idx[0] = 12'h563; win_idx[1] = 12'hAC6;
        win_idx[2] = 12'h58D; win_idx[3] = 12'h634;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state rejects everything
        lookup(UNI,   1'b0, 2'd0, "R1 unicast after reset");
        lookup(EXMC,  1'b0, 2'd0, "R1 multicast after reset");
        lookup(BCAST, 1'b0, 2'd0, "R1 broadcast after reset");

        // R3 / R5: exact slots
        set_slot(0, A0);
        lookup(A0, 1'b1, 2'd1, "R5 slot 0 exact");
        lookup(A0 ^ (48'h1 << 40), 1'b0, 2'd0, "R3 byte 5 differs");
        lookup(A0 ^ (48'h1 << 8),  1'b0, 2'd0, "R3 byte 1 differs");
        set_slot(15, A15);
        lookup(A15, 1'b1, 2'd1, "R5 slot 15 exact");
        set_slot(7, M7);
        lookup(M7, 1'b1, 2'd1, "R5 group address in slot 7");

        // R4: valid flag gates the slot
        host_write(6'd31, {1'b0, 15'd0, A15[47:32]});
        lookup(A15, 1'b0, 2'd0, "R4 slot 15 invalidated");
        host_write(6'd31, {1'b1, 15'd0, A15[47:32]});
        lookup(A15, 1'b1, 2'd1, "R4 slot 15 revalidated");

        // R6: each window with its example hash
        for (int m = 0; m < 4; m++) begin
            hash_wipe();
            set_ctrl(2'(m), 1'b0, 1'b0);
            hash_set(win_idx[m]);
            lookup(EXMC, 1'b1, 2'd2, $sformatf("R6 window %0d hit", m));
            set_ctrl(2'((m + 1) % 4), 1'b0, 1'b0);
            lookup(EXMC, 1'b0, 2'd0, $sformatf("R6 window %0d under other window", m));
        end

        // R7: bit indexing and OR behaviour
        hash_wipe();
        set_ctrl(2'd3, 1'b0, 1'b0);
        hash_set(12'h634);
        lookup(48'h0635_0000_0001, 1'b0, 2'd0, "R7 neighbour bit clear");
        lookup(48'h0654_0000_0001, 1'b0, 2'd0, "R7 other word same bit clear");
        hash_set(12'h635);
        lookup(EXMC, 1'b1, 2'd2, "R7 first bit kept after second set");
        lookup(48'h0635_0000_0001, 1'b1, 2'd2, "R7 second bit set");

        // R9: group bit required for hash acceptance
        lookup(48'h0635_0000_0000, 1'b0, 2'd0, "R9 unicast with set hash bit");

        // R8: wipe
        hash_wipe();
        lookup(EXMC, 1'b0, 2'd0, "R8 wipe clears bit 0x634");
        lookup(48'h0635_0000_0001, 1'b0, 2'd0, "R8 wipe clears bit 0x635");

        // R11: exact wins over hash (M7 window 3 hash 0x122)
        hash_set(12'h122);
        lookup(M7, 1'b1, 2'd1, "R11 exact over hash");

        // R10: broadcast enable
        set_slot(2, BCAST);
        hash_set(12'hFFF);
        lookup(BCAST, 1'b0, 2'd0, "R10 broadcast disabled");
        set_ctrl(2'd3, 1'b1, 1'b0);
        lookup(BCAST, 1'b1, 2'd3, "R10 broadcast enabled");

        // R12: promiscuous
        set_ctrl(2'd3, 1'b0, 1'b1);
        lookup(UNI,   1'b1, 2'd0, "R12 promiscuous unknown unicast");
        lookup(A0,    1'b1, 2'd1, "R12 promiscuous exact kind");
        lookup(BCAST, 1'b1, 2'd0, "R12 promiscuous broadcast disabled");

        // R13: same-cycle write sees old contents
        set_ctrl(2'd3, 1'b0, 1'b0);
        hash_wipe();
        host_write(6'd8, A4[31:0]);
        write_and_lookup(6'd9, {1'b1, 15'd0, A4[47:32]}, A4, 1'b0, 2'd0, "R13 slot write same cycle");
        lookup(A4, 1'b1, 2'd1, "R13 slot after write");
        write_and_lookup(6'd33, 32'h634, EXMC, 1'b0, 2'd0, "R13 hash set same cycle");
        lookup(EXMC, 1'b1, 2'd2, "R13 hash after set");
        write_and_lookup(6'd9, {1'b0, 15'd0, A4[47:32]}, A4, 1'b1, 2'd1, "R13 invalidate same cycle");
        lookup(A4, 1'b0, 2'd0, "R13 slot after invalidate");

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R2 all results delivered",
              $sformatf("%0d pending", exp_q.size()), "0 pending");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule